// File: doc/BRIEF.md
# Tag Check Fault Responder

This block sits after a memory-tag comparator and turns a single tag-mismatch event into the report the processor has asked for. A two-bit response mode is read out of a wide control word. Which two bits are used depends on whether the failing access was made at the unprivileged level. The mode then selects one of four outcomes: ignore the failure, raise a synchronous abort request, set a sticky asynchronous fault flag, or split the response by access direction.

A synchronous report is a one-cycle request pulse. It is registered together with a small syndrome, made of a fixed fault status code plus the write indication, and with the faulting virtual address. An asynchronous report ORs one bit into a two-bit sticky flag register. The bit is picked by a chosen address bit when the translation regime splits the address space into two ranges; otherwise it is bit 0. Only a separate software clear port with a per-bit mask removes flags. Taking the exception itself is left to the surrounding core.

Top module: `tag_fault_responder`

## Requirements
- R1: For an unprivileged access (`unpriv_i`=1) the mode is `ctrl_i[39:38]`; otherwise it is `ctrl_i[41:40]`. Modes: 0 off, 1 synchronous, 2 asynchronous, 3 split.
- R2: With mode 0, a failure raises no `sync_req_o` and leaves `async_flags_o` unchanged.
- R3: With mode 1, every failure, load or store, raises `sync_req_o` in the cycle after `fail_i` and sets no flag.
- R4: With mode 2, every failure sets an asynchronous flag and raises no `sync_req_o`.
- R5: With mode 3, a store (`is_write_i`=1) sets an asynchronous flag, and a load raises `sync_req_o` and sets no flag.
- R6: The flag set is index `fault_addr_i[55]` when `two_range_i`=1, and index 0 otherwise. The new bit is ORed into the existing flags.
- R7: A set flag stays set until a cycle with `sw_clr_i`=1 whose `sw_clr_mask_i` has that bit set; that clear takes effect at the next clock edge.
- R8: When a clear and a flag set land in the same cycle, the newly set bit survives and the clear applies to the other bits.
- R9: `sync_req_o` is high for exactly one cycle per synchronous failure. With it, `syndrome_o[5:0]`=0x11, `syndrome_o[6]`=`is_write_i`, and `sync_addr_o`=`fault_addr_i` of the failing access. Both hold their values until the next synchronous report.
- R10: After reset, `sync_req_o`, `syndrome_o`, `sync_addr_o` and `async_flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fail_i | input | 1 | Tag-check failure strobe, one per failing access |
| fault_addr_i | input | 64 | Virtual address of the failing access |
| is_write_i | input | 1 | 1 for a store, 0 for a load |
| unpriv_i | input | 1 | Access made at the unprivileged level |
| two_range_i | input | 1 | Translation regime has two address ranges |
| ctrl_i | input | 64 | Control word holding both mode fields |
| sw_clr_i | input | 1 | Software clear strobe for the flags |
| sw_clr_mask_i | input | 2 | Per-flag clear mask |
| sync_req_o | output | 1 | Synchronous abort request pulse |
| syndrome_o | output | 7 | {write, status code} of the last synchronous report |
| sync_addr_o | output | 64 | Fault address of the last synchronous report |
| async_flags_o | output | 2 | Sticky asynchronous fault flags |

## Verification
The assertions assume that `ctrl_i`, `unpriv_i`, `is_write_i`, `two_range_i` and `fault_addr_i` are stable and meaningful in any cycle where `fail_i` is high. They also assume the clear mask only matters when `sw_clr_i` is high. The stimulus changes every input only at the falling edge and raises `fail_i` for a single cycle at a time. It sweeps all four modes in both mode fields, both privilege levels, both directions, both range settings and both values of address bit 55. The field that is not selected always holds a different mode, so a wrong field choice shows up as a wrong response.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int FSC_W = 6;
  localparam logic [FSC_W-1:0] TAG_FSC = 6'h11;
  localparam int SYN_W = FSC_W + 1;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_ASYNC = 2'd2,
    MODE_SPLIT = 2'd3
  } resp_mode_e;

  // synchronous report wanted for this mode and direction
  function automatic logic wants_sync(resp_mode_e m, logic wr);
    return (m == MODE_SYNC) || ((m == MODE_SPLIT) && !wr);
  endfunction

  // asynchronous flag wanted for this mode and direction
  function automatic logic wants_async(resp_mode_e m, logic wr);
    return (m == MODE_ASYNC) || ((m == MODE_SPLIT) && wr);
  endfunction

  function automatic logic [SYN_W-1:0] make_syndrome(logic wr);
    return {wr, TAG_FSC};
  endfunction
endpackage

// File: rtl/tfr_mode_select.sv
module tfr_mode_select
  import tfr_pkg::*;
#(
  parameter int CTRL_W     = 64,
  parameter int UNPRIV_LSB = 38,
  parameter int PRIV_LSB   = 40
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              unpriv_i,
  output resp_mode_e        mode_o
);
  logic ctrl_unused;
  assign ctrl_unused = ^ctrl_i;

  logic [1:0] unpriv_field, priv_field;
  assign unpriv_field = ctrl_i[UNPRIV_LSB +: 2];
  assign priv_field   = ctrl_i[PRIV_LSB +: 2];

  assign mode_o = resp_mode_e'(unpriv_i ? unpriv_field : priv_field);
endmodule

// File: rtl/tfr_response_decode.sv
module tfr_response_decode
  import tfr_pkg::*;
(
  input  logic       fail_i,
  input  resp_mode_e mode_i,
  input  logic       is_write_i,
  output logic       sync_hit_o,
  output logic       async_hit_o
);
  assign sync_hit_o  = fail_i && wants_sync(mode_i, is_write_i);
  assign async_hit_o = fail_i && wants_async(mode_i, is_write_i);
endmodule

// File: rtl/tfr_async_flags.sv
module tfr_async_flags #(
  parameter int NFLAGS = 2,
  localparam int IDX_W = (NFLAGS > 1) ? $clog2(NFLAGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              async_hit_i,
  input  logic [IDX_W-1:0]  sel_bits_i,
  input  logic              two_range_i,
  input  logic              clr_i,
  input  logic [NFLAGS-1:0] clr_mask_i,
  output logic [NFLAGS-1:0] set_vec_o,
  output logic [NFLAGS-1:0] flags_o
);
  logic [IDX_W-1:0] idx;
  assign idx = two_range_i ? sel_bits_i : '0;

  logic [NFLAGS-1:0] flags_q;

  for (genvar k = 0; k < NFLAGS; k++) begin : g_flag
    assign set_vec_o[k] = async_hit_i && (idx == IDX_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[k] <= 1'b0;
      end else begin
        // set is applied after the clear so a same-cycle set survives
        flags_q[k] <= (flags_q[k] && !(clr_i && clr_mask_i[k])) || set_vec_o[k];
      end
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/tag_fault_responder.sv
module tag_fault_responder
  import tfr_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int CTRL_W     = 64,
  parameter int SEL_BIT    = 55,
  parameter int UNPRIV_LSB = 38,
  parameter int PRIV_LSB   = 40,
  parameter int NFLAGS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic              is_write_i,
  input  logic              unpriv_i,
  input  logic              two_range_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              sw_clr_i,
  input  logic [NFLAGS-1:0] sw_clr_mask_i,
  output logic              sync_req_o,
  output logic [SYN_W-1:0]  syndrome_o,
  output logic [ADDR_W-1:0] sync_addr_o,
  output logic [NFLAGS-1:0] async_flags_o
);
  localparam int IDX_W = (NFLAGS > 1) ? $clog2(NFLAGS) : 1;

  resp_mode_e        mode;
  logic              sync_hit;
  logic              async_hit;
  logic [NFLAGS-1:0] set_vec;

  tfr_mode_select #(
    .CTRL_W(CTRL_W), .UNPRIV_LSB(UNPRIV_LSB), .PRIV_LSB(PRIV_LSB)
  ) u_mode (
    .ctrl_i(ctrl_i), .unpriv_i(unpriv_i), .mode_o(mode)
  );

  tfr_response_decode u_dec (
    .fail_i(fail_i), .mode_i(mode), .is_write_i(is_write_i),
    .sync_hit_o(sync_hit), .async_hit_o(async_hit)
  );

  tfr_async_flags #(.NFLAGS(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .async_hit_i(async_hit),
    .sel_bits_i(fault_addr_i[SEL_BIT +: IDX_W]),
    .two_range_i(two_range_i),
    .clr_i(sw_clr_i), .clr_mask_i(sw_clr_mask_i),
    .set_vec_o(set_vec), .flags_o(async_flags_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_req_o  <= 1'b0;
      syndrome_o  <= '0;
      sync_addr_o <= '0;
    end else begin
      sync_req_o <= sync_hit;
      if (sync_hit) begin
        syndrome_o  <= make_syndrome(is_write_i);
        sync_addr_o <= fault_addr_i;
      end
    end
  end
endmodule

// File: rtl/tfr_chk.sv
module tfr_chk #(
  parameter int ADDR_W  = 64,
  parameter int CTRL_W  = 64,
  parameter int SEL_BIT = 55,
  parameter int NFLAGS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fail_i,
  input logic [ADDR_W-1:0] fault_addr_i,
  input logic              is_write_i,
  input logic              unpriv_i,
  input logic              two_range_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              sw_clr_i,
  input logic [NFLAGS-1:0] sw_clr_mask_i,
  input logic              sync_req_o,
  input logic [6:0]        syndrome_o,
  input logic [ADDR_W-1:0] sync_addr_o,
  input logic [NFLAGS-1:0] async_flags_o,
  input logic              sync_hit,
  input logic              async_hit,
  input logic [NFLAGS-1:0] set_vec
);
  // R1
  unpriv_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_i && unpriv_i && ctrl_i[39:38] == 2'd1) |=> sync_req_o);

  // R1
  priv_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_i && !unpriv_i && ctrl_i[41:40] == 2'd1) |=> sync_req_o);

  // R2
  mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_i && !sw_clr_i &&
     (unpriv_i ? ctrl_i[39:38] : ctrl_i[41:40]) == 2'd0)
    |=> (!sync_req_o && $stable(async_flags_o)));

  // R5
  exclusive_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_hit && async_hit));

  // R6
  upper_flag_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[1] |-> (two_range_i && fault_addr_i[SEL_BIT]));

  // R7
  sticky0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_flags_o[0] && !(sw_clr_i && sw_clr_mask_i[0])) |=> async_flags_o[0]);

  // R7
  sticky1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_flags_o[1] && !(sw_clr_i && sw_clr_mask_i[1])) |=> async_flags_o[1]);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> async_flags_o[0]);

  // R9
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_req_o) |-> $past(fail_i));

  // R9
  syndrome_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req_o |-> (syndrome_o[5:0] == 6'h11));

  // R9
  report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req_o |-> ($stable(sync_addr_o) || $past(!rst_n)));
endmodule

bind tag_fault_responder tfr_chk #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .SEL_BIT(SEL_BIT), .NFLAGS(NFLAGS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fail_i(fail_i), .fault_addr_i(fault_addr_i),
  .is_write_i(is_write_i), .unpriv_i(unpriv_i), .two_range_i(two_range_i),
  .ctrl_i(ctrl_i), .sw_clr_i(sw_clr_i), .sw_clr_mask_i(sw_clr_mask_i),
  .sync_req_o(sync_req_o), .syndrome_o(syndrome_o), .sync_addr_o(sync_addr_o),
  .async_flags_o(async_flags_o), .sync_hit(sync_hit), .async_hit(async_hit),
  .set_vec(set_vec)
);

// File: tb/tag_fault_responder_tb.sv
module tag_fault_responder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fail_i = 1'b0;
  logic [63:0] fault_addr_i = '0;
  logic        is_write_i = 1'b0;
  logic        unpriv_i = 1'b0;
  logic        two_range_i = 1'b0;
  logic [63:0] ctrl_i = '0;
  logic        sw_clr_i = 1'b0;
  logic [1:0]  sw_clr_mask_i = '0;
  logic        sync_req_o;
  logic [6:0]  syndrome_o;
  logic [63:0] sync_addr_o;
  logic [1:0]  async_flags_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [63:0] last_addr = '0;
  logic [6:0]  last_syn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_fault_responder dut_i (
    .clk(clk), .rst_n(rst_n), .fail_i(fail_i), .fault_addr_i(fault_addr_i),
    .is_write_i(is_write_i), .unpriv_i(unpriv_i), .two_range_i(two_range_i),
    .ctrl_i(ctrl_i), .sw_clr_i(sw_clr_i), .sw_clr_mask_i(sw_clr_mask_i),
    .sync_req_o(sync_req_o), .syndrome_o(syndrome_o), .sync_addr_o(sync_addr_o),
    .async_flags_o(async_flags_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // control word with mode m in the chosen field and its complement in the other
  function automatic logic [63:0] make_ctrl(int m, bit up);
    logic [63:0] c = 64'hF0F0_F0F0_F0F0_F0F0;
    logic [1:0] mm = 2'(m);
    c[39:38] = up ? mm : ~mm;
    c[41:40] = up ? ~mm : mm;
    return c;
  endfunction

  task automatic clear_all();
    @(negedge clk);
    fail_i = 1'b0; sw_clr_i = 1'b1; sw_clr_mask_i = 2'b11;
    @(negedge clk);
    sw_clr_i = 1'b0; sw_clr_mask_i = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 sync_req", {63'd0, sync_req_o}, 64'd0);
    check("R10 syndrome", {57'd0, syndrome_o}, 64'd0);
    check("R10 addr", sync_addr_o, 64'd0);
    check("R10 flags", {62'd0, async_flags_o}, 64'd0);
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++)
      for (int up = 0; up < 2; up++)
        for (int wr = 0; wr < 2; wr++)
          for (int tr = 0; tr < 2; tr++)
            for (int b55 = 0; b55 < 2; b55++) begin
              bit exp_sync, exp_async;
              logic [1:0] exp_flags;
              logic [63:0] a;
              string tag;
              clear_all();
              a = 64'h0012_3456_789A_BC00 ^ 64'(m*16 + up*8 + wr*4 + tr*2 + b55);
              a[55] = b55[0];
              exp_sync  = (m == 1) || (m == 3 && wr == 0);
              exp_async = (m == 2) || (m == 3 && wr == 1);
              exp_flags = 2'b00;
              if (exp_async) exp_flags[(tr == 1) ? b55 : 0] = 1'b1;
              // R2 off, R3 sync, R4 async, R5 split
              tag = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
              fail_i = 1'b1; fault_addr_i = a; is_write_i = wr[0];
              unpriv_i = up[0]; two_range_i = tr[0]; ctrl_i = make_ctrl(m, up[0]);
              @(negedge clk);
              fail_i = 1'b0;
              if (exp_sync) begin
                last_addr = a;
                last_syn = {wr[0], 6'h11};
              end
              // R1: wrong field choice would change these
              check({tag, "/R1 sync_req"}, {63'd0, sync_req_o}, {63'd0, exp_sync});
              // R6 flag index
              check({tag, "/R6 flags"}, {62'd0, async_flags_o}, {62'd0, exp_flags});
              // R9 report contents
              check("R9 addr", sync_addr_o, last_addr);
              check("R9 syndrome", {57'd0, syndrome_o}, {57'd0, last_syn});
              @(negedge clk);
              check("R9 one-cycle pulse", {63'd0, sync_req_o}, 64'd0);
              check("R7 sticky", {62'd0, async_flags_o}, {62'd0, exp_flags});
            end

    // R8: clear and set in the same cycle
    clear_all();
    fail_i = 1'b1; ctrl_i = make_ctrl(2, 1'b0); unpriv_i = 1'b0;
    two_range_i = 1'b0; fault_addr_i = 64'h0;
    @(negedge clk);
    fail_i = 1'b1; two_range_i = 1'b1; fault_addr_i = 64'h0080_0000_0000_0000;
    sw_clr_i = 1'b1; sw_clr_mask_i = 2'b11;
    @(negedge clk);
    fail_i = 1'b0; sw_clr_i = 1'b0; sw_clr_mask_i = 2'b00;
    check("R8 set survives clear", {62'd0, async_flags_o}, 64'd2);

    // R7: partial clear by mask
    fail_i = 1'b1; two_range_i = 1'b0; fault_addr_i = 64'h0;
    @(negedge clk);
    fail_i = 1'b0;
    check("R7 both set", {62'd0, async_flags_o}, 64'd3);
    sw_clr_i = 1'b1; sw_clr_mask_i = 2'b01;
    @(negedge clk);
    sw_clr_i = 1'b0; sw_clr_mask_i = 2'b00;
    check("R7 masked clear", {62'd0, async_flags_o}, 64'd2);
    repeat (3) @(negedge clk);
    check("R7 held", {62'd0, async_flags_o}, 64'd2);
    check("R9 addr held", sync_addr_o, last_addr);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule